// File: doc/BRIEF.md
# Multi-Channel Prescaled Pulse-Width Modulator

This block drives several independent pulse-width modulated outputs. Each output has one 32-bit control word. A channel divides the source clock by a programmable prescale count plus one. Every resulting tick steps an 8-bit position counter, so one output period is always 256 ticks long. During each period the output is high while the position is below an 8-bit duty value. A separate bit holds the output high for the whole period.

Software writes and reads the control words through a plain synchronous write port and a combinational read port. Changes take effect on the clock edge that captures the write. No channel waits for its current period to finish before it applies a new setting or shuts down. When the enable bit is cleared, the output drops low, and the next enable starts a fresh period from position zero.

Top module: `pwm_ctrl_top`

## Requirements
- R1: Control word fields: prescale count in bits [12:0], duty in bits [23:16], force-high in bit 24, enable in bit 31. Channel k is selected when addr[ADDR_W-1:4] equals k. addr[3:0] are don't-care.
- R2: A read of a mapped channel returns the last value written to it, with bits [15:13] and [30:25] as zero. Reads of an unmapped channel return zero, and writes to one change no channel.
- R3: Reset, whether applied at start-up or while channels run, clears every control word to zero and drives every output low.
- R4: One output period lasts 256*(SCALE+1) source clocks. With SCALE = 0 the position advances on every clock.
- R5: An enabled channel without force-high is high for the first DUTY*(SCALE+1) clocks of each period and low for the rest. The first period starts on the clock edge that captures the enabling write.
- R6: With force-high set and the channel enabled, the output is high continuously and DUTY has no effect.
- R7: With DUTY = 0 and force-high clear, an enabled output stays low for the whole period.
- R8: A write that clears enable drives the output low from the capturing edge, abandoning the period in progress. A later enable restarts at position zero.
- R9: Rewriting an enabled channel applies the new fields at once and keeps the current period position, so the period still ends where it would have.
- R10: Channels are independent: a write to one channel leaves the outputs and words of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, captured on the rising clock edge |
| addr | input | ADDR_W | Byte address; bits [ADDR_W-1:4] select the channel |
| wdata | input | 32 | Control word to write |
| rdata | output | 32 | Control word of the addressed channel, combinational |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The hardest case to reach from the ports is a rewrite that lands in the middle of a running period. The bench must show both results together: the output reacts at once to the new duty, and the period position is kept. The stimulus enables a channel, waits a known number of clocks, and then rewrites the duty to a value below the current position. The output must fall on the next sample and rise again exactly 256 positions after the original enable. A disable in mid-period followed by a re-enable shows the restart from position zero in the same way.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;

    localparam int REG_W     = 32;
    localparam int SCALE_W   = 13;
    localparam int DUTY_W    = 8;
    localparam int SCALE_LSB = 0;
    localparam int DUTY_LSB  = 16;
    localparam int FULL_BIT  = 24;
    localparam int EN_BIT    = 31;

    typedef struct packed {
        logic                en;
        logic                full;
        logic [DUTY_W-1:0]   duty;
        logic [SCALE_W-1:0]  scale;
    } pwm_cfg_t;

    function automatic pwm_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
        pwm_cfg_t c;
        logic     unused_bits;
        unused_bits = ^w;
        c.en    = w[EN_BIT];
        c.full  = w[FULL_BIT];
        c.duty  = w[DUTY_LSB +: DUTY_W];
        c.scale = w[SCALE_LSB +: SCALE_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input pwm_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[EN_BIT]                 = c.en;
        w[FULL_BIT]               = c.full;
        w[DUTY_LSB +: DUTY_W]     = c.duty;
        w[SCALE_LSB +: SCALE_W]   = c.scale;
        return w;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_ctrl_pkg::*;
#(
    parameter int DIV_W = SCALE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    // A stale count above a freshly lowered limit wraps at once.
    assign tick = run && (st_q.cnt >= limit);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pwm_cfg_t cfg,
    output logic     pwm
);

    typedef struct packed {
        logic [DUTY_W-1:0] pos;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        tick;

    pwm_prescaler #(
        .DIV_W (SCALE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg.en),
        .limit (cfg.scale),
        .tick  (tick)
    );

    always_comb begin
        st_d = st_q;
        if (!cfg.en) begin
            st_d.pos = '0;
        end else if (tick) begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    assign pwm = cfg.en && (cfg.full || (st_q.pos < cfg.duty));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_ctrl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    output pwm_cfg_t [NUM_CH-1:0]        cfg
);

    localparam int SEL_W = ADDR_W - 4;

    typedef struct packed {
        pwm_cfg_t [NUM_CH-1:0] word;
    } rf_state_t;

    rf_state_t         st_d, st_q;
    logic [SEL_W-1:0]  sel;
    logic              unused_low;

    assign sel        = addr[ADDR_W-1:4];
    assign unused_low = ^addr[3:0];

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_CH; k++) begin
            if (wr_en && (sel == SEL_W'(k))) begin
                st_d.word[k] = word_to_cfg(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (sel == SEL_W'(k)) begin
                rdata = cfg_to_word(st_q.word[k]);
            end
        end
    end

    assign cfg = st_q.word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_ctrl_top.sv
module pwm_ctrl_top
    import pwm_ctrl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    pwm_cfg_t [NUM_CH-1:0] cfg;

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg[g]),
            .pwm   (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [NUM_CH-1:0] pwm_out
);

    localparam int          SEL_W = ADDR_W - 4;
    localparam logic [31:0] KEEP  = 32'h81FF_1FFF;

    logic [SEL_W-1:0] sel;
    logic             mapped;

    assign sel    = addr[ADDR_W-1:4];
    assign mapped = (int'(sel) < NUM_CH);

    // R3: outputs stay low while reset is held
    assert_reset_low_R3: assert property (@(posedge clk)
        !rst_n |-> (pwm_out == '0));

    // R2: a mapped write reads back masked on the next cycle
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mapped) |=> ((addr != $past(addr)) || (rdata == ($past(wdata) & KEEP))));

    // R2: unmapped addresses read as zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == '0));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        // R8: clearing enable drops the output on the capturing edge
        assert_off_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (sel == SEL_W'(k)) && !wdata[31]) |=> !pwm_out[k]);

        // R6: force-high gives a high output right away
        assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (sel == SEL_W'(k)) && wdata[31] && wdata[24]) |=> pwm_out[k]);

        // R7: zero duty without force-high gives a low output
        assert_zero_duty_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (sel == SEL_W'(k)) && wdata[31] && !wdata[24] && (wdata[23:16] == 8'd0))
            |=> !pwm_out[k]);
    end

endmodule

bind pwm_ctrl_top pwm_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pwm_out (pwm_out)
);

// File: tb/pwm_ctrl_top_tb_top.sv
module pwm_ctrl_top_tb_top;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 8;

    typedef struct packed {
        logic [12:0] scale;
        logic [7:0]  duty;
        logic        full;
        logic [15:0] hi;
        logic [15:0] per;
    } vec_t;

    // expected high length = duty*(scale+1) (or whole period when forced), period = 256*(scale+1)
    localparam vec_t VECS [7] = '{
        '{13'd0, 8'd128, 1'b0, 16'd128, 16'd256},
        '{13'd0, 8'd1,   1'b0, 16'd1,   16'd256},
        '{13'd0, 8'd255, 1'b0, 16'd255, 16'd256},
        '{13'd1, 8'd64,  1'b0, 16'd128, 16'd512},
        '{13'd3, 8'd10,  1'b0, 16'd40,  16'd1024},
        '{13'd2, 8'd0,   1'b1, 16'd768, 16'd768},
        '{13'd1, 8'd0,   1'b0, 16'd0,   16'd512}
    };

    logic              clk;
    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic [NUM_CH-1:0] pwm_out;

    int tests;
    int fails;
    bit done;

    pwm_ctrl_top #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [31:0] mk(input logic en, input logic full,
                                       input logic [7:0] duty, input logic [12:0] scale);
        return {en, 6'b0, full, duty, 3'b0, scale};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the capturing edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          bad;
        int          hi_seen;
        tests = 0;
        fails = 0;
        done  = 1'b0;
        rst_n = 1'b0;
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        for (int c = 0; c < NUM_CH; c++) begin
            rd(ADDR_W'(c * 16), v);
            chk(v == 32'h0, "R3 reset word", v, 0);
        end
        chk(pwm_out == '0, "R3 reset outputs", pwm_out, 0);

        // R4 R5 R6 R7: vector table on channel 0
        foreach (VECS[i]) begin
            wr(8'h00, 32'h0);
            wr(8'h00, mk(1'b1, VECS[i].full, VECS[i].duty, VECS[i].scale));
            bad     = 0;
            hi_seen = 0;
            for (int t = 0; t < int'(VECS[i].per); t++) begin
                if (pwm_out[0]) hi_seen++;
                if (pwm_out[0] != (t < int'(VECS[i].hi))) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R5 R6 R7 waveform shape", hi_seen, VECS[i].hi);
            chk(pwm_out[0] == (VECS[i].hi != 0), "R4 period restart", pwm_out[0], VECS[i].hi != 0);
        end

        // R2 R1: masked readback, low address bits ignored
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v);
        chk(v == 32'h81FF_1FFF, "R2 masked readback", v, 32'h81FF_1FFF);
        rd(8'h1B, v);
        chk(v == 32'h81FF_1FFF, "R1 low address bits ignored", v, 32'h81FF_1FFF);
        chk(pwm_out[1] == 1'b1, "R1 enable and force bit positions", pwm_out[1], 1);

        // R2: unmapped channel
        wr(8'h40, 32'h8100_0000);
        rd(8'h40, v);
        chk(v == 32'h0, "R2 unmapped reads zero", v, 0);
        rd(8'h30, v);
        chk(v == 32'h0, "R2 unmapped write ignored", v, 0);
        chk(pwm_out[3] == 1'b0, "R2 unmapped write no output", pwm_out[3], 0);

        // R10: independence
        wr(8'h20, mk(1'b1, 1'b1, 8'd0, 13'd0));
        wr(8'h30, mk(1'b1, 1'b0, 8'd0, 13'd0));
        wr(8'h10, 32'h0);
        chk(pwm_out[3:1] == 3'b010, "R10 channel outputs", pwm_out[3:1], 3'b010);
        rd(8'h20, v);
        chk(v == 32'h8100_0000, "R10 neighbour word kept", v, 32'h8100_0000);

        // R8: disable mid-period, then restart from zero
        wr(8'h00, 32'h0);
        wr(8'h00, mk(1'b1, 1'b0, 8'd200, 13'd0));
        repeat (10) @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R8 high before disable", pwm_out[0], 1);
        wr(8'h00, mk(1'b0, 1'b0, 8'd200, 13'd0));
        chk(pwm_out[0] == 1'b0, "R8 low at disable", pwm_out[0], 0);
        repeat (3) @(negedge clk);
        chk(pwm_out[0] == 1'b0, "R8 stays low", pwm_out[0], 0);
        wr(8'h00, mk(1'b1, 1'b0, 8'd5, 13'd0));
        bad = 0;
        for (int t = 0; t < 7; t++) begin
            if (pwm_out[0] != (t < 5)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R8 restart from zero", bad, 0);

        // R9: rewrite mid-period keeps position
        wr(8'h00, 32'h0);
        wr(8'h00, mk(1'b1, 1'b0, 8'd100, 13'd0));
        repeat (50) @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R9 high before rewrite", pwm_out[0], 1);
        wr(8'h00, mk(1'b1, 1'b0, 8'd30, 13'd0));
        chk(pwm_out[0] == 1'b0, "R9 new duty at once", pwm_out[0], 0);
        repeat (204) @(negedge clk);
        chk(pwm_out[0] == 1'b0, "R9 low at position 255", pwm_out[0], 0);
        @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R9 period end kept", pwm_out[0], 1);

        // R3: reset while running
        rst_n = 1'b0;
        #1;
        chk(pwm_out == '0, "R3 reset mid-run outputs", pwm_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h20, v);
        chk(v == 32'h0, "R3 reset mid-run word", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule